// File: doc/BRIEF.md
# Per-Subband Array Covariance Integrator

This block builds the sample correlation matrix of a receiving antenna array, with one matrix for each frequency subband. Each input beat holds one complex sample from every array element, all taken at the same time instant in the same subband. The beat also carries the number of its subband. For every element pair (r, c) with r <= c, the block multiplies element r's sample by the complex conjugate of element c's sample. It adds that product into the accumulator that belongs to the pair and to the subband. Because each matrix is Hermitian, only the upper triangle is stored, diagonal included. The diagonal terms come out purely real.

An integration window holds `N_GROUPS` groups of `GROUP_LEN` time steps, which is 4250 steps by default. During each time step every subband delivers exactly one beat, and the subbands may come in any order. When the final beat of a window has been added, the block raises `done` for one cycle. It then streams every stored entry out on a valid/ready port, subband by subband, and within a subband row by row and column by column. Each entry is cleared once it has been handed over, so the next window starts from zero.

Back-pressure rules: the input port takes a beat on any rising edge where `s_valid` and `s_ready` are both high. `s_ready` is low for the whole time the result is being streamed out. On the output port, an entry is taken when `m_valid` and `m_ready` are both high. While `m_ready` is low, the entry and its coordinates stay unchanged.

Top module: `cov_integrator`

## Requirements
- R1: While reset is asserted and right after it is released, `s_ready` is 1, `m_valid` is 0 and `done` is 0.
- R2: The entry at (r, c) accumulates x_r·conj(x_c). Its real part adds re_r·re_c + im_r·im_c and its imaginary part adds im_r·re_c − re_r·im_c. Element e's sample sits in `s_data`, with the real part at bits [16e+7:16e] and the imaginary part at bits [16e+15:16e+8], both signed two's complement.
- R3: A beat whose `s_sub` is s changes only the matrix of subband s. Subbands may arrive in any order within a time step.
- R4: `done` is high for exactly one cycle, the cycle right after the edge that accepted beat number `N_SUB·GROUP_LEN·N_GROUPS` of the window. `m_valid` rises in that same cycle.
- R5: Entries come out with subband ascending, then row r ascending, then column c running from r to `N_ELEM`−1. `m_last` is high only on the entry for the last subband with row and column both equal to `N_ELEM`−1.
- R6: While `m_valid` is high and `m_ready` is low, `m_sub`, `m_row`, `m_col`, `m_re` and `m_im` hold their values.
- R7: `s_ready` is low for as long as `m_valid` is high. It returns to 1 in the cycle after the handshake of the `m_last` entry.
- R8: Every window starts from zero accumulators, whatever the previous window held.
- R9: Accumulators are 2·`SAMP_W`+1+ceil(log2(window length)) bits wide, so a window of full-scale samples gives exact sums with no wrap.
- R10: On diagonal entries (`m_row` = `m_col`), `m_im` is 0 and `m_re` is not negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block can accept a beat |
| s_sub | input | SUB_W | Subband index of the beat, below N_SUB |
| s_data | input | N_ELEM·2·SAMP_W | One complex sample per element |
| m_valid | output | 1 | Output entry valid |
| m_ready | input | 1 | Downstream takes the entry |
| m_sub | output | SUB_W | Subband of the entry |
| m_row | output | ROW_W | Row index r |
| m_col | output | ROW_W | Column index c, with c ≥ r |
| m_last | output | 1 | Final entry of the window |
| m_re | output | ACC_W | Real part of the sum, signed |
| m_im | output | ACC_W | Imaginary part of the sum, signed |
| done | output | 1 | One-cycle pulse at the end of a window |

## Verification
A beat accepted at a rising edge is inside the accumulator from the next cycle on. After the window's final beat, `done` and the first output entry both show up one cycle later. Each output handshake brings the next entry into view one cycle after its edge, and `s_ready` comes back one cycle after the final handshake. The bench samples every output at the falling edge. It compares them with a behavioural model that records handshakes at that same falling edge, so every expected value already includes the edge still to come, and all outputs are compared on every clock.

// File: rtl/cov_pkg.sv
package cov_pkg;
  // number of stored entries of an n x n Hermitian matrix (upper triangle)
  function automatic int pair_count(input int n);
    return n * (n + 1) / 2;
  endfunction

  // linear index of entry (r, r) in row-major upper-triangle order
  function automatic int row_base(input int r, input int n);
    return r * n - (r * (r - 1)) / 2;
  endfunction

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cov_xprod.sv
module cov_xprod #(
  parameter int N_ELEM = 16,
  parameter int SAMP_W = 8,
  parameter int PROD_W = 2 * SAMP_W + 1,
  parameter int NPAIR  = cov_pkg::pair_count(N_ELEM)
) (
  input  logic [N_ELEM*2*SAMP_W-1:0] samples,
  output logic signed [PROD_W-1:0]   p_re [NPAIR],
  output logic signed [PROD_W-1:0]   p_im [NPAIR]
);
  for (genvar r = 0; r < N_ELEM; r++) begin : g_row
    logic signed [SAMP_W-1:0] ar, ai;
    logic signed [PROD_W-1:0] xr, xi;
    assign ar = samples[r*2*SAMP_W +: SAMP_W];
    assign ai = samples[r*2*SAMP_W+SAMP_W +: SAMP_W];
    assign xr = PROD_W'(ar);
    assign xi = PROD_W'(ai);
    for (genvar c = r; c < N_ELEM; c++) begin : g_col
      localparam int K = cov_pkg::row_base(r, N_ELEM) + (c - r);
      logic signed [SAMP_W-1:0] br, bi;
      logic signed [PROD_W-1:0] yr, yi;
      assign br = samples[c*2*SAMP_W +: SAMP_W];
      assign bi = samples[c*2*SAMP_W+SAMP_W +: SAMP_W];
      assign yr = PROD_W'(br);
      assign yi = PROD_W'(bi);
      // x_r * conj(x_c)
      assign p_re[K] = xr * yr + xi * yi;
      if (c == r) begin : g_diag
        assign p_im[K] = '0;
      end else begin : g_off
        assign p_im[K] = xi * yr - xr * yi;
      end
    end
  end
endmodule

// File: rtl/cov_acc_bank.sv
module cov_acc_bank #(
  parameter int N_SUB  = 8,
  parameter int NPAIR  = 136,
  parameter int PROD_W = 17,
  parameter int ACC_W  = 30,
  parameter int SUB_W  = 3,
  parameter int PAIR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     add_en,
  input  logic [SUB_W-1:0]         add_sub,
  input  logic signed [PROD_W-1:0] p_re [NPAIR],
  input  logic signed [PROD_W-1:0] p_im [NPAIR],
  input  logic                     clr_en,
  input  logic [SUB_W-1:0]         rd_sub,
  input  logic [PAIR_W-1:0]        rd_pair,
  output logic signed [ACC_W-1:0]  rd_re,
  output logic signed [ACC_W-1:0]  rd_im
);
  logic signed [ACC_W-1:0] acc_re [N_SUB][NPAIR];
  logic signed [ACC_W-1:0] acc_im [N_SUB][NPAIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SUB; s++)
        for (int k = 0; k < NPAIR; k++) begin
          acc_re[s][k] <= '0;
          acc_im[s][k] <= '0;
        end
    end else if (add_en) begin
      for (int k = 0; k < NPAIR; k++) begin
        acc_re[add_sub][k] <= acc_re[add_sub][k] + ACC_W'(p_re[k]);
        acc_im[add_sub][k] <= acc_im[add_sub][k] + ACC_W'(p_im[k]);
      end
    end else if (clr_en) begin
      acc_re[rd_sub][rd_pair] <= '0;
      acc_im[rd_sub][rd_pair] <= '0;
    end
  end

  assign rd_re = acc_re[rd_sub][rd_pair];
  assign rd_im = acc_im[rd_sub][rd_pair];

  for (genvar k = 0; k < NPAIR; k++) begin : g_ovf
    logic signed [ACC_W-1:0] cur_re, ext_re, sum_re, cur_im, ext_im, sum_im;
    assign cur_re = acc_re[add_sub][k];
    assign ext_re = ACC_W'(p_re[k]);
    assign sum_re = cur_re + ext_re;
    assign cur_im = acc_im[add_sub][k];
    assign ext_im = ACC_W'(p_im[k]);
    assign sum_im = cur_im + ext_im;
    AST_NO_OVERFLOW_RE: assert property (@(posedge clk) disable iff (!rst_n)
      add_en && (cur_re[ACC_W-1] == ext_re[ACC_W-1]) |-> sum_re[ACC_W-1] == cur_re[ACC_W-1]); // R9
    AST_NO_OVERFLOW_IM: assert property (@(posedge clk) disable iff (!rst_n)
      add_en && (cur_im[ACC_W-1] == ext_im[ACC_W-1]) |-> sum_im[ACC_W-1] == cur_im[ACC_W-1]); // R9
  end
endmodule

// File: rtl/cov_win_ctrl.sv
module cov_win_ctrl #(
  parameter int N_ELEM    = 16,
  parameter int N_SUB     = 8,
  parameter int GROUP_LEN = 85,
  parameter int N_GROUPS  = 50,
  parameter int SUB_W     = 3,
  parameter int ROW_W     = 4,
  parameter int PAIR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              add_en,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              clr_en,
  output logic [SUB_W-1:0]  rd_sub,
  output logic [ROW_W-1:0]  rd_row,
  output logic [ROW_W-1:0]  rd_col,
  output logic [PAIR_W-1:0] rd_pair,
  output logic              m_last,
  output logic              done
);
  localparam int T_W = cov_pkg::idx_w(GROUP_LEN);
  localparam int G_W = cov_pkg::idx_w(N_GROUPS);
  localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(N_SUB - 1);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(N_ELEM - 1);

  logic             draining;
  logic [SUB_W-1:0] beat_sub;
  logic [T_W-1:0]   t_idx;
  logic [G_W-1:0]   g_idx;
  logic             last_beat, fire;

  assign s_ready   = !draining;
  assign add_en    = s_valid && s_ready;
  assign m_valid   = draining;
  assign fire      = m_valid && m_ready;
  assign clr_en    = fire;
  assign last_beat = (beat_sub == SUB_MAX) && (t_idx == T_W'(GROUP_LEN - 1))
                   && (g_idx == G_W'(N_GROUPS - 1));
  assign m_last    = draining && (rd_sub == SUB_MAX) && (rd_row == ROW_MAX)
                   && (rd_col == ROW_MAX);

  // intake counters: beats within a time step, steps within a group, groups
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_sub <= '0;
      t_idx    <= '0;
      g_idx    <= '0;
    end else if (add_en) begin
      if (beat_sub == SUB_MAX) begin
        beat_sub <= '0;
        if (t_idx == T_W'(GROUP_LEN - 1)) begin
          t_idx <= '0;
          g_idx <= (g_idx == G_W'(N_GROUPS - 1)) ? '0 : g_idx + 1'b1;
        end else begin
          t_idx <= t_idx + 1'b1;
        end
      end else begin
        beat_sub <= beat_sub + 1'b1;
      end
    end
  end

  // drain sequencing over subband, row, column
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draining <= 1'b0;
      done     <= 1'b0;
      rd_sub   <= '0;
      rd_row   <= '0;
      rd_col   <= '0;
      rd_pair  <= '0;
    end else begin
      done <= add_en && last_beat;
      if (add_en && last_beat) draining <= 1'b1;
      else if (fire && m_last) draining <= 1'b0;
      if (fire) begin
        if (rd_col == ROW_MAX) begin
          if (rd_row == ROW_MAX) begin
            rd_row  <= '0;
            rd_col  <= '0;
            rd_pair <= '0;
            rd_sub  <= (rd_sub == SUB_MAX) ? '0 : rd_sub + 1'b1;
          end else begin
            rd_row  <= rd_row + 1'b1;
            rd_col  <= rd_row + 1'b1;
            rd_pair <= rd_pair + 1'b1;
          end
        end else begin
          rd_col  <= rd_col + 1'b1;
          rd_pair <= rd_pair + 1'b1;
        end
      end
    end
  end

  AST_NO_INTAKE_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready); // R7
  AST_HOLD_COORD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(rd_sub) && $stable(rd_row) && $stable(rd_col)); // R6
  AST_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> rd_row <= rd_col); // R5
  AST_DONE_STARTS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> m_valid && rd_sub == '0 && rd_row == '0 && rd_col == '0); // R4
endmodule

// File: rtl/cov_integrator.sv
module cov_integrator #(
  parameter int N_ELEM    = 16,
  parameter int N_SUB     = 8,
  parameter int SAMP_W    = 8,
  parameter int GROUP_LEN = 85,
  parameter int N_GROUPS  = 50,
  localparam int WIN_LEN  = GROUP_LEN * N_GROUPS,
  localparam int NPAIR    = cov_pkg::pair_count(N_ELEM),
  localparam int PROD_W   = 2 * SAMP_W + 1,
  localparam int ACC_W    = PROD_W + cov_pkg::idx_w(WIN_LEN),
  localparam int SUB_W    = cov_pkg::idx_w(N_SUB),
  localparam int ROW_W    = cov_pkg::idx_w(N_ELEM),
  localparam int PAIR_W   = cov_pkg::idx_w(NPAIR)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [SUB_W-1:0]          s_sub,
  input  logic [N_ELEM*2*SAMP_W-1:0] s_data,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [SUB_W-1:0]          m_sub,
  output logic [ROW_W-1:0]          m_row,
  output logic [ROW_W-1:0]          m_col,
  output logic                      m_last,
  output logic signed [ACC_W-1:0]   m_re,
  output logic signed [ACC_W-1:0]   m_im,
  output logic                      done
);
  logic signed [PROD_W-1:0] p_re [NPAIR];
  logic signed [PROD_W-1:0] p_im [NPAIR];
  logic                     add_en, clr_en;
  logic [PAIR_W-1:0]        rd_pair;

  cov_xprod #(.N_ELEM(N_ELEM), .SAMP_W(SAMP_W), .PROD_W(PROD_W), .NPAIR(NPAIR)) u_xprod (
    .samples(s_data), .p_re(p_re), .p_im(p_im));

  cov_win_ctrl #(.N_ELEM(N_ELEM), .N_SUB(N_SUB), .GROUP_LEN(GROUP_LEN), .N_GROUPS(N_GROUPS),
                 .SUB_W(SUB_W), .ROW_W(ROW_W), .PAIR_W(PAIR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .add_en(add_en),
    .m_valid(m_valid), .m_ready(m_ready), .clr_en(clr_en), .rd_sub(m_sub),
    .rd_row(m_row), .rd_col(m_col), .rd_pair(rd_pair), .m_last(m_last), .done(done));

  cov_acc_bank #(.N_SUB(N_SUB), .NPAIR(NPAIR), .PROD_W(PROD_W), .ACC_W(ACC_W),
                 .SUB_W(SUB_W), .PAIR_W(PAIR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .add_en(add_en), .add_sub(s_sub), .p_re(p_re), .p_im(p_im),
    .clr_en(clr_en), .rd_sub(m_sub), .rd_pair(rd_pair), .rd_re(m_re), .rd_im(m_im));

  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> s_sub < SUB_W'(N_SUB - 1) || s_sub == SUB_W'(N_SUB - 1)); // R3
  AST_DIAG_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_row == m_col |-> m_im == '0 && !m_re[ACC_W-1]); // R10
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> $stable(m_re) && $stable(m_im)); // R6
endmodule

// File: tb/tb_cov_integrator.sv
module tb_cov_integrator;
  localparam int NE = 3, NS = 3, SW = 8, GL = 3, NG = 2;
  localparam int WIN = GL * NG;
  localparam int NP = NE * (NE + 1) / 2;
  localparam int ACCW = 2 * SW + 1 + $clog2(WIN);
  localparam int SUBW = $clog2(NS);
  localparam int ROWW = $clog2(NE);
  localparam int BEATS = WIN * NS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b1, m_last, done;
  logic [SUBW-1:0] s_sub = '0, m_sub;
  logic [NE*2*SW-1:0] s_data;
  logic [ROWW-1:0] m_row, m_col;
  logic signed [ACCW-1:0] m_re, m_im;

  cov_integrator #(.N_ELEM(NE), .N_SUB(NS), .SAMP_W(SW), .GROUP_LEN(GL), .N_GROUPS(NG)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_sub(s_sub),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_sub(m_sub), .m_row(m_row),
    .m_col(m_col), .m_last(m_last), .m_re(m_re), .m_im(m_im), .done(done));

  always #10 clk = ~clk;

  int cur_re [NE];
  int cur_im [NE];
  always_comb
    for (int e = 0; e < NE; e++) begin
      s_data[e*2*SW +: SW]      = SW'(cur_re[e]);
      s_data[e*2*SW+SW +: SW]   = SW'(cur_im[e]);
    end

  typedef struct { int sub; int row; int col; longint re; longint im; bit last; int win; } ent_t;
  ent_t q[$];
  longint ref_re [NS][NP];
  longint ref_im [NS][NP];
  int checks = 0, errors = 0, beats = 0, win = 0;
  bit done_exp = 0, bp_on = 0, finished = 0;
  bit prev_hold = 0;
  longint prev_re, prev_im;
  int prev_sub, prev_row, prev_col;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string val_tag(input int w);
    case (w)
      0: return "R2";
      1: return "R3";
      2: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // reference model, compared on every falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(s_ready == 1'b1, "R1", "s_ready in reset", s_ready, 1);
      chk(m_valid == 1'b0, "R1", "m_valid in reset", m_valid, 0);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
    end else begin
      chk(s_ready == (q.size() == 0), "R7", "s_ready", s_ready, q.size() == 0);
      chk(done == done_exp, "R4", "done", done, done_exp);
      chk(m_valid == (q.size() != 0), "R4", "m_valid", m_valid, q.size() != 0);
      done_exp = 0;
      if (m_valid && q.size() != 0) begin
        ent_t e;
        e = q[0];
        chk(int'(m_sub) == e.sub, "R5", "m_sub", m_sub, e.sub);
        chk(int'(m_row) == e.row, "R5", "m_row", m_row, e.row);
        chk(int'(m_col) == e.col, "R5", "m_col", m_col, e.col);
        chk(m_last == e.last, "R5", "m_last", m_last, e.last);
        chk(longint'(m_re) == e.re, val_tag(e.win), "m_re", m_re, e.re);
        chk(longint'(m_im) == e.im, val_tag(e.win), "m_im", m_im, e.im);
        if (e.row == e.col) begin
          chk(m_im == 0, "R10", "diag m_im", m_im, 0);
          chk(m_re >= 0, "R10", "diag m_re sign", m_re, e.re);
        end
      end
      if (prev_hold) begin
        chk(m_valid && longint'(m_re) == prev_re && longint'(m_im) == prev_im &&
            int'(m_sub) == prev_sub && int'(m_row) == prev_row && int'(m_col) == prev_col,
            "R6", "held entry re", m_re, prev_re);
      end
      prev_hold = m_valid && !m_ready;
      prev_re = m_re; prev_im = m_im;
      prev_sub = m_sub; prev_row = m_row; prev_col = m_col;
      if (m_valid && m_ready && q.size() != 0) void'(q.pop_front());
      if (s_valid && s_ready) begin
        int s, k;
        s = int'(s_sub);
        k = 0;
        for (int r = 0; r < NE; r++)
          for (int c = r; c < NE; c++) begin
            ref_re[s][k] += longint'(cur_re[r] * cur_re[c] + cur_im[r] * cur_im[c]);
            ref_im[s][k] += longint'(cur_im[r] * cur_re[c] - cur_re[r] * cur_im[c]);
            k++;
          end
        beats++;
        if (beats == BEATS) begin
          beats = 0;
          done_exp = 1;
          for (int sb = 0; sb < NS; sb++) begin
            int kk;
            kk = 0;
            for (int r = 0; r < NE; r++)
              for (int c = r; c < NE; c++) begin
                ent_t e;
                e.sub = sb; e.row = r; e.col = c;
                e.re = ref_re[sb][kk]; e.im = ref_im[sb][kk];
                e.last = (sb == NS - 1) && (r == NE - 1) && (c == NE - 1);
                e.win = win;
                q.push_back(e);
                ref_re[sb][kk] = 0; ref_im[sb][kk] = 0;
                kk++;
              end
          end
          win++;
        end
      end
    end
  end

  // downstream ready pattern
  initial begin
    forever begin
      @(posedge clk); #2;
      m_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic send_beat(input int sub, input int mode);
    bit acc;
    for (int e = 0; e < NE; e++) begin
      if (mode == 1) begin
        cur_re[e] = (e % 2 == 1) ? 127 : -128;
        cur_im[e] = -128;
      end else begin
        cur_re[e] = int'($urandom % 256) - 128;
        cur_im[e] = int'($urandom % 256) - 128;
      end
    end
    s_sub = SUBW'(sub);
    s_valid = 1'b1;
    do begin
      @(negedge clk);
      acc = s_ready;
      @(posedge clk); #2;
    end while (!acc);
    s_valid = 1'b0;
    if ($urandom % 4 == 0) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic send_window(input int mode);
    for (int g = 0; g < NG; g++)
      for (int t = 0; t < GL; t++)
        for (int j = 0; j < NS; j++)
          send_beat(((t % 2) == 1) ? (NS - 1 - j) : j, mode);
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin cur_re[e] = 0; cur_im[e] = 0; end
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NP; k++) begin ref_re[s][k] = 0; ref_im[s][k] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    send_window(0);              // R2 random data
    bp_on = 1;
    send_window(0);              // R3 reordered subbands, R6 back-pressure
    send_window(1);              // R9 full-scale samples
    bp_on = 0;
    send_window(0);              // R8 fresh window after large sums
    while (q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
    finish_run();
  end
endmodule